// File: doc/BRIEF.md
# Audio Signal Presence Detector

This block decides whether a real signal is present on an audio sample stream. It compares each signed sample's magnitude against a programmable level. A presence flag rises only after enough consecutive loud samples, and falls only after enough consecutive quiet ones. This hysteresis in time keeps short clicks from waking the system and short pauses from shutting it down. The surrounding system uses the flag to power converters up or down.

Two identical channels sit inside the top: one for the capture (recording) path and one for the playback path. Each channel has its own sample strobe, its own sample, its own level and its own flag. The run-length limits and the enable bit are common to both channels. Counting advances only on a sample strobe, so a step is one sample period, whatever the clock rate.

Top module: `presence_detector`

## Requirements
- R1: While reset is asserted, both flags are low and both run counters clear, so a full run of qualifying samples is needed after reset before a flag can rise.
- R2: A sample counts as loud only when its magnitude is strictly greater than the channel level multiplied by 128 (level shifted left by 7). A magnitude equal to that threshold counts as quiet.
- R3: The comparison is symmetric in sign: a negative sample is loud when its absolute value exceeds the threshold, and this includes the most negative code -32768.
- R4: A flag rises at the clock edge that takes the N-th consecutive loud strobed sample, where N is the 8-bit on-time. An on-time of 0 acts as 1. The flag is visible in the cycle after that edge.
- R5: Any quiet strobed sample restarts the loud run, so a later rise again needs N consecutive loud samples.
- R6: A raised flag falls at the edge that takes the M-th consecutive quiet strobed sample. M is the 16-bit off-time, built from a low byte (bits 7:0) and a high byte (bits 15:8). An off-time of 0 acts as 1.
- R7: Any loud strobed sample restarts the quiet run, so a later fall again needs M consecutive quiet samples.
- R8: In a cycle without a sample strobe, the flag and both run counts keep their values, whatever the sample input holds.
- R9: With the enable low, both flags are forced low at the next edge and both run counts clear. After the enable returns high, a full loud run is needed again.
- R10: The run counters saturate at their all-ones value and never wrap. An on-time of 255 and an off-time of 65535 are therefore honoured exactly, and the flag stays stable when a run goes on past its limit.
- R11: The capture and playback channels are independent: each one uses only its own strobe, sample and level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Detector enable, shared by both channels |
| on_time | input | 8 | Loud samples needed to raise a flag |
| off_time_lo | input | 8 | Quiet-run limit, bits 7:0 |
| off_time_hi | input | 8 | Quiet-run limit, bits 15:8 |
| cap_level | input | 8 | Capture threshold level (times 128) |
| cap_valid | input | 1 | Capture sample strobe |
| cap_sample | input | 16 | Capture sample, two's complement |
| cap_active | output | 1 | Capture presence flag |
| play_level | input | 8 | Playback threshold level (times 128) |
| play_valid | input | 1 | Playback sample strobe |
| play_sample | input | 16 | Playback sample, two's complement |
| play_active | output | 1 | Playback presence flag |

## Verification
The bench uses the default parameters: 16-bit samples, an 8-bit on-time counter, a 16-bit off-time counter and a shift of 7. With these widths the largest limits, 255 loud samples and 65535 quiet samples, can be run within the cycle budget. The saturation boundaries and the byte order of the off-time are therefore hit exactly, not only the small limits. A level of 0x10 places the threshold at 2048, so the equality case, the just-above case and the most negative code all sit in one short vector table.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic {
    PD_QUIET = 1'b0,
    PD_LIVE  = 1'b1
  } pd_state_e;

  localparam int PD_CHANNELS = 2;
endpackage

// File: rtl/pd_level_cmp.sv
module pd_level_cmp #(
  parameter int DATA_W    = 16,
  parameter int REF_W     = 8,
  parameter int REF_SHIFT = 7
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic        [REF_W-1:0]  level,
  output logic                     loud
);
  localparam int MAG_W = DATA_W + 1;

  function automatic logic [MAG_W-1:0] magnitude(input logic signed [DATA_W-1:0] s);
    logic signed [MAG_W-1:0] wide;
    wide = MAG_W'(s);
    return s[DATA_W-1] ? $unsigned(-wide) : $unsigned(wide);
  endfunction

  function automatic logic [MAG_W-1:0] threshold(input logic [REF_W-1:0] l);
    return MAG_W'(l) << REF_SHIFT;
  endfunction

  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] thr;

  assign mag  = magnitude(sample);
  assign thr  = threshold(level);
  assign loud = (mag > thr);

  always_comb begin
    if (!$isunknown(sample) && !$isunknown(level))
      AST_LOUD_IMPLIES_NONZERO: assert (!loud || mag != '0); // R2
  end
endmodule

// File: rtl/pd_run_counter.sv
module pd_run_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_inc,
  output logic         at_max
);
  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (&v) ? v : v + W'(1);
  endfunction

  assign cnt_inc = sat_inc(cnt);
  assign at_max  = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt_inc;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !clr) |=> at_max); // R10
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R5
endmodule

// File: rtl/pd_channel.sv
module pd_channel
  import pd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int REF_W     = 8,
  parameter int REF_SHIFT = 7,
  parameter int ON_W      = 8,
  parameter int OFF_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     valid,
  input  logic signed [DATA_W-1:0] sample,
  input  logic        [REF_W-1:0]  level,
  input  logic        [ON_W-1:0]   on_limit,
  input  logic        [OFF_W-1:0]  off_limit,
  output logic                     active
);
  logic             loud;
  logic             take_loud;
  logic             take_quiet;
  logic [ON_W-1:0]  on_cnt, on_next;
  logic [OFF_W-1:0] off_cnt, off_next;
  logic             on_sat, off_sat;
  logic             on_hit, off_hit;
  pd_state_e        state;

  pd_level_cmp #(.DATA_W(DATA_W), .REF_W(REF_W), .REF_SHIFT(REF_SHIFT)) u_cmp (
    .sample(sample), .level(level), .loud(loud)
  );

  assign take_loud  = enable & valid & loud;
  assign take_quiet = enable & valid & ~loud;

  pd_run_counter #(.W(ON_W)) u_on (
    .clk(clk), .rst_n(rst_n), .clr(~enable | take_quiet), .inc(take_loud),
    .cnt(on_cnt), .cnt_inc(on_next), .at_max(on_sat)
  );

  pd_run_counter #(.W(OFF_W)) u_off (
    .clk(clk), .rst_n(rst_n), .clr(~enable | take_loud), .inc(take_quiet),
    .cnt(off_cnt), .cnt_inc(off_next), .at_max(off_sat)
  );

  assign on_hit  = take_loud  && (on_next  >= on_limit);
  assign off_hit = take_quiet && (off_next >= off_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= PD_QUIET;
    else if (!enable) state <= PD_QUIET;
    else if (on_hit)  state <= PD_LIVE;
    else if (off_hit) state <= PD_QUIET;
  end

  assign active = (state == PD_LIVE);

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !active); // R9
  AST_RISE_NEEDS_LOUD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(enable && valid && loud)); // R4
  AST_FALL_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(!enable || (valid && !loud))); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !valid) |=> $stable(active)); // R8
  AST_RUNS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !((on_cnt != '0) && (off_cnt != '0))); // R7
  AST_SAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(on_sat && off_sat)); // R10
endmodule

// File: rtl/presence_detector.sv
module presence_detector
  import pd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int REF_W     = 8,
  parameter int REF_SHIFT = 7,
  parameter int ON_W      = 8,
  parameter int OFF_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [ON_W-1:0]          on_time,
  input  logic [OFF_W/2-1:0]       off_time_lo,
  input  logic [OFF_W/2-1:0]       off_time_hi,
  input  logic [REF_W-1:0]         cap_level,
  input  logic                     cap_valid,
  input  logic signed [DATA_W-1:0] cap_sample,
  output logic                     cap_active,
  input  logic [REF_W-1:0]         play_level,
  input  logic                     play_valid,
  input  logic signed [DATA_W-1:0] play_sample,
  output logic                     play_active
);
  localparam int NCH = PD_CHANNELS;

  logic [OFF_W-1:0]         off_limit;
  logic [NCH-1:0]           ch_valid;
  logic [NCH-1:0]           ch_active;
  logic signed [DATA_W-1:0] ch_sample [NCH];
  logic [REF_W-1:0]         ch_level  [NCH];

  assign off_limit    = {off_time_hi, off_time_lo};
  assign ch_valid     = {play_valid, cap_valid};
  assign ch_sample[0] = cap_sample;
  assign ch_sample[1] = play_sample;
  assign ch_level[0]  = cap_level;
  assign ch_level[1]  = play_level;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pd_channel #(
      .DATA_W(DATA_W), .REF_W(REF_W), .REF_SHIFT(REF_SHIFT),
      .ON_W(ON_W), .OFF_W(OFF_W)
    ) u_ch (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .valid(ch_valid[g]), .sample(ch_sample[g]), .level(ch_level[g]),
      .on_limit(on_time), .off_limit(off_limit), .active(ch_active[g])
    );
  end

  assign cap_active  = ch_active[0];
  assign play_active = ch_active[1];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!cap_active && !play_active)); // R1
endmodule

// File: tb/sim_presence_detector.sv
module sim_presence_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic [7:0] on_time = 8'd3;
  logic [7:0] off_time_lo = 8'd2;
  logic [7:0] off_time_hi = 8'd0;
  logic [7:0] cap_level = 8'h10;
  logic [7:0] play_level = 8'h40;
  logic cap_valid = 1'b0, play_valid = 1'b0;
  logic signed [15:0] cap_sample = '0, play_sample = '0;
  logic cap_active, play_active;

  int checks = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  presence_detector u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .on_time(on_time),
    .off_time_lo(off_time_lo), .off_time_hi(off_time_hi),
    .cap_level(cap_level), .cap_valid(cap_valid), .cap_sample(cap_sample),
    .cap_active(cap_active), .play_level(play_level), .play_valid(play_valid),
    .play_sample(play_sample), .play_active(play_active)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  // valid, sample, expected capture flag
  localparam int NV = 16;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 16'sd2049,   1'b0},  // R2 just above, run 1
    {1'b1, 16'sd2048,   1'b0},  // R2 equality is quiet
    {1'b1, -16'sd2049,  1'b0},  // R3 negative loud, run 1
    {1'b0, 16'sd30000,  1'b0},  // R8 no strobe
    {1'b1, 16'sd30000,  1'b0},  // run 2
    {1'b1, -16'sd32768, 1'b1},  // R3 R4 run 3 raises
    {1'b1, 16'sd100,    1'b1},  // quiet 1
    {1'b1, 16'sd5000,   1'b1},  // R7 loud clears quiet run
    {1'b1, -16'sd2048,  1'b1},  // quiet 1
    {1'b0, 16'sd0,      1'b1},  // R8 no strobe
    {1'b1, 16'sd0,      1'b0},  // R6 quiet 2 drops
    {1'b1, 16'sd3000,   1'b0},  // run 1
    {1'b1, 16'sd0,      1'b0},  // R5 restart
    {1'b1, 16'sd3000,   1'b0},
    {1'b1, 16'sd3000,   1'b0},
    {1'b1, 16'sd3000,   1'b1}   // R5 full run again
  };

  task automatic check(input logic act, input logic exp, input string tag);
    checks = checks + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic cv, input logic signed [15:0] cs,
                      input logic pv, input logic signed [15:0] ps);
    cap_valid = cv; cap_sample = cs; play_valid = pv; play_sample = ps;
    @(posedge clk); #2;
    cap_valid = 1'b0; play_valid = 1'b0;
  endtask

  task automatic run_cap(input int n, input logic signed [15:0] s);
    for (int i = 0; i < n; i++) step(1'b1, s, 1'b0, 16'sd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); #2;
    rst_n = 1'b1;
  endtask

  initial begin
    @(posedge clk); #2;
    check(cap_active, 1'b0, "R1 cap low in reset");
    check(play_active, 1'b0, "R1 play low in reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][17], VEC[i][16:1], 1'b0, 16'sd0);
      check(cap_active, VEC[i][0], $sformatf("R4/R6 table row %0d", i));
      check(play_active, 1'b0, $sformatf("R11 play idle row %0d", i));
    end

    // R9: disable drops flag and clears run
    enable = 1'b0; step(1'b0, 16'sd0, 1'b0, 16'sd0);
    check(cap_active, 1'b0, "R9 disable forces low");
    enable = 1'b1;
    run_cap(2, 16'sd3000);
    check(cap_active, 1'b0, "R9 run cleared by disable");
    run_cap(1, 16'sd3000);
    check(cap_active, 1'b1, "R9 full run after enable");

    // R1: reset in mid-run
    do_reset();
    check(cap_active, 1'b0, "R1 reset drops flag");
    run_cap(2, 16'sd3000);
    check(cap_active, 1'b0, "R1 run cleared by reset");
    run_cap(1, 16'sd3000);
    check(cap_active, 1'b1, "R1 full run after reset");

    // R4/R6: zero limits act as one
    on_time = 8'd0; off_time_lo = 8'd0; off_time_hi = 8'd0;
    do_reset();
    run_cap(1, 16'sd3000);
    check(cap_active, 1'b1, "R4 on-time 0 rises on first");
    run_cap(1, 16'sd0);
    check(cap_active, 1'b0, "R6 off-time 0 falls on first");

    // R10: on-time 255
    on_time = 8'd255;
    run_cap(254, 16'sd3000);
    check(cap_active, 1'b0, "R10 on 254 of 255");
    run_cap(1, 16'sd3000);
    check(cap_active, 1'b1, "R10 on 255 rises");
    run_cap(300, 16'sd3000);
    check(cap_active, 1'b1, "R10 on saturated stays");

    // R6: byte order, off-time 0x0102 = 258
    off_time_lo = 8'h02; off_time_hi = 8'h01;
    run_cap(257, 16'sd0);
    check(cap_active, 1'b1, "R6 off 257 of 258");
    run_cap(1, 16'sd0);
    check(cap_active, 1'b0, "R6 off 258 falls");

    // R10: off-time 65535
    on_time = 8'd1;
    run_cap(1, 16'sd3000);
    check(cap_active, 1'b1, "R10 re-raise");
    off_time_lo = 8'hFF; off_time_hi = 8'hFF;
    run_cap(65534, 16'sd0);
    check(cap_active, 1'b1, "R10 off 65534 of 65535");
    run_cap(1, 16'sd0);
    check(cap_active, 1'b0, "R10 off 65535 falls");
    run_cap(10, 16'sd0);
    check(cap_active, 1'b0, "R10 off saturated stays");

    // R11: independent channels, play threshold 8192
    off_time_lo = 8'd1; off_time_hi = 8'd0;
    step(1'b1, 16'sd5000, 1'b1, 16'sd5000);
    check(cap_active, 1'b1, "R11 cap loud at 5000");
    check(play_active, 1'b0, "R11 play quiet at 5000");
    step(1'b0, 16'sd0, 1'b1, -16'sd8193);
    check(play_active, 1'b1, "R11 play loud at -8193");
    check(cap_active, 1'b1, "R11 cap unaffected");
    step(1'b1, 16'sd0, 1'b0, 16'sd0);
    check(cap_active, 1'b0, "R11 cap falls alone");
    check(play_active, 1'b1, "R11 play holds");

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule